// File: doc/BRIEF.md
# Replayable Fault Throttling Tracker

This block sits beside a compute unit's TLB and keeps track of translation requests that the memory management unit answered with a replayable negative acknowledgement. The memory management unit can only hold a fixed number of outstanding faults for each compute unit, and that number is known to the tracker as a parameter. The tracker counts the acknowledgements whose faults are still being handled. While the count is below that number, a new acknowledgement is taken to be serviced. It is parked in a slot until the memory management unit sends a replay notice for its page, and it is then handed back to the TLB for translation. An acknowledgement that arrives when the count already equals the limit must have been dropped by the memory management unit. Such a request goes into a first-in first-out queue and is re-issued once a serviced fault has completed.

Each tracked request carries its virtual page number and the warp that issued it. The tracker drives a per-warp stall mask, so the scheduler holds only the waiting warps while all other warps keep issuing. A re-issued request that faults again comes back as an ordinary new acknowledgement.

Control is a three-state machine. `ST_IDLE` accepts replay notices. `ST_SEND_SERVICED` presents a request released by a matched notice. `ST_SEND_DROPPED` presents the oldest queued dropped request. Named transitions: IDLE to SEND_SERVICED on a notice that matches a slot. IDLE to SEND_DROPPED when no notice is offered, the queue is not empty and the count is below the limit. Either SEND state returns to IDLE when the TLB accepts the request. In all other cases the machine stays where it is.

Top module: `replay_tracker`

## Requirements
- R1: After reset `reissue_valid` is 0, `stall_mask` is all zero, and both `nack_ready` and `notice_ready` are 1.
- R2: An accepted acknowledgement arriving while the pending count is below FAULT_LIMIT is stored in a slot as serviced, and the count rises by one. Bit `nack_warp` of `stall_mask` is 1 from the next cycle on.
- R3: An accepted acknowledgement arriving while the count equals FAULT_LIMIT is treated as dropped. It is appended to the dropped queue, the count does not change, and a later notice for its page does not match it.
- R4: A notice accepted in ST_IDLE whose page equals a serviced slot frees that slot and lowers the count by one. From the next cycle `reissue_valid` is 1 with that slot's page and warp.
- R5: Dropped requests are re-issued oldest first. One is taken only in ST_IDLE, with no notice offered and the count below FAULT_LIMIT, and it appears on `reissue_*` in the following cycle.
- R6: A notice that matches no slot is consumed with no re-issue and no change to the count. The count never goes below zero.
- R7: Bit w of `stall_mask` is 1 exactly while some slot, queue entry or presented re-issue carries warp w.
- R8: `nack_ready` is 0 only when the count equals FAULT_LIMIT and the dropped queue holds DROP_DEPTH entries. An acknowledgement offered while it is 0 is ignored.
- R9: While `reissue_valid` is 1 and `reissue_ready` is 0, the presented page and warp stay unchanged and `notice_ready` is 0.
- R10: A re-issued request that faults again is accepted as a new acknowledgement under R2 or R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nack_valid | input | 1 | Replayable negative acknowledgement offered |
| nack_ready | output | 1 | Tracker can take an acknowledgement |
| nack_vpn | input | VPN_W | Page of the acknowledged request |
| nack_warp | input | WARP_W | Warp that issued the acknowledged request |
| notice_valid | input | 1 | Replay notice from the memory management unit |
| notice_ready | output | 1 | Notice consumed this cycle (ST_IDLE) |
| notice_vpn | input | VPN_W | Page whose fault has been resolved |
| reissue_valid | output | 1 | A request is presented for re-translation |
| reissue_ready | input | 1 | TLB takes the presented request |
| reissue_vpn | output | VPN_W | Page to re-translate |
| reissue_warp | output | WARP_W | Warp owning the presented request |
| stall_mask | output | NUM_WARPS | One bit per warp that must be held |

## Verification
A wrong pending count shows up at the boundary. The acknowledgement that should go to the queue takes a slot, or the reverse, and the next notice for that page then produces a re-issue that should not happen, or fails to produce one. The stimulus therefore fills the slots, overfills the queue and sends notices both for dropped pages and for unknown pages. A corrupted slot or queue entry shows on `stall_mask` one cycle after the edge that wrote it, and on `reissue_vpn` one cycle after the notice or queue pop that reads it. Queue ordering faults appear as out-of-order pages on consecutive re-issues.

// File: rtl/rtrk_pkg.sv
package rtrk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE          = 2'd0,
        ST_SEND_SERVICED = 2'd1,
        ST_SEND_DROPPED  = 2'd2
    } rtrk_state_e;
endpackage

// File: rtl/rtrk_slot_table.sv
module rtrk_slot_table #(
    parameter int SLOTS     = 2,
    parameter int VPN_W     = 20,
    parameter int NUM_WARPS = 8,
    localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic [VPN_W-1:0]     alloc_vpn,
    input  logic [WARP_W-1:0]    alloc_warp,
    input  logic [VPN_W-1:0]     lookup_vpn,
    input  logic                 free_en,
    output logic                 hit,
    output logic [VPN_W-1:0]     hit_vpn,
    output logic [WARP_W-1:0]    hit_warp,
    output logic                 any_free,
    output logic [NUM_WARPS-1:0] warp_mask
);
    logic [SLOTS-1:0]  v_q;
    logic [VPN_W-1:0]  vpn_q  [SLOTS];
    logic [WARP_W-1:0] warp_q [SLOTS];
    logic [SLOTS-1:0]  match;
    logic [IDX_W-1:0]  alloc_idx, hit_idx;

    for (genvar s = 0; s < SLOTS; s++) begin : g_match
        assign match[s] = v_q[s] && (vpn_q[s] == lookup_vpn);
    end

    always_comb begin
        alloc_idx = '0;
        hit_idx   = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (!v_q[s])  alloc_idx = IDX_W'(s);
            if (match[s]) hit_idx   = IDX_W'(s);
        end
        hit      = |match;
        any_free = ~&v_q;
        hit_vpn  = vpn_q[hit_idx];
        hit_warp = warp_q[hit_idx];
        warp_mask = '0;
        for (int s = 0; s < SLOTS; s++)
            if (v_q[s]) warp_mask[warp_q[s]] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int s = 0; s < SLOTS; s++) begin
                vpn_q[s]  <= '0;
                warp_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (alloc_en && alloc_idx == IDX_W'(s)) begin
                    v_q[s]    <= 1'b1;
                    vpn_q[s]  <= alloc_vpn;
                    warp_q[s] <= alloc_warp;
                end else if (free_en && hit && hit_idx == IDX_W'(s)) begin
                    v_q[s] <= 1'b0;
                end
            end
        end
    end

    // R2: a serviced acknowledgement always finds a free slot
    assert_slot_available_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> any_free);
    // R4: a freed slot no longer matches its page
    assert_free_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en && hit && $countones(match) == 1) |=> !(|(match & $past(match))) || $past(alloc_en));
endmodule

// File: rtl/rtrk_drop_fifo.sv
module rtrk_drop_fifo #(
    parameter int DEPTH     = 4,
    parameter int VPN_W     = 20,
    parameter int NUM_WARPS = 8,
    localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [VPN_W-1:0]     push_vpn,
    input  logic [WARP_W-1:0]    push_warp,
    input  logic                 pop,
    output logic [VPN_W-1:0]     head_vpn,
    output logic [WARP_W-1:0]    head_warp,
    output logic                 empty,
    output logic                 full,
    output logic [NUM_WARPS-1:0] warp_mask
);
    logic [VPN_W-1:0]  vpn_q  [DEPTH];
    logic [WARP_W-1:0] warp_q [DEPTH];
    logic [PTR_W-1:0]  rd_q, wr_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign head_vpn  = vpn_q[rd_q];
    assign head_warp = warp_q[rd_q];

    always_comb begin
        warp_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (((i + DEPTH - int'(rd_q)) % DEPTH) < int'(cnt_q))
                warp_mask[warp_q[i]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                vpn_q[i]  <= '0;
                warp_q[i] <= '0;
            end
        end else begin
            if (push) begin
                vpn_q[wr_q]  <= push_vpn;
                warp_q[wr_q] <= push_warp;
                wr_q         <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R8: nothing is written into a full queue
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5: nothing is taken from an empty queue
    assert_no_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/replay_tracker.sv
module replay_tracker
    import rtrk_pkg::*;
#(
    parameter int NUM_WARPS   = 8,
    parameter int FAULT_LIMIT = 2,
    parameter int DROP_DEPTH  = 4,
    parameter int VPN_W       = 20,
    localparam int WARP_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nack_valid,
    output logic                 nack_ready,
    input  logic [VPN_W-1:0]     nack_vpn,
    input  logic [WARP_W-1:0]    nack_warp,
    input  logic                 notice_valid,
    output logic                 notice_ready,
    input  logic [VPN_W-1:0]     notice_vpn,
    output logic                 reissue_valid,
    input  logic                 reissue_ready,
    output logic [VPN_W-1:0]     reissue_vpn,
    output logic [WARP_W-1:0]    reissue_warp,
    output logic [NUM_WARPS-1:0] stall_mask
);
    localparam int CNT_W = $clog2(FAULT_LIMIT + 1);

    rtrk_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [VPN_W-1:0]   out_vpn_q;
    logic [WARP_W-1:0]  out_warp_q;

    logic below_limit, nack_fire, notice_fire, alloc, push, free, pop;
    logic slot_hit, slot_free, q_empty, q_full;
    logic [VPN_W-1:0]     slot_vpn, q_vpn;
    logic [WARP_W-1:0]    slot_warp, q_warp;
    logic [NUM_WARPS-1:0] slot_mask, q_mask, held_mask;

    assign below_limit  = (cnt_q < CNT_W'(FAULT_LIMIT));
    assign nack_ready   = below_limit || !q_full;
    assign nack_fire    = nack_valid && nack_ready;
    assign alloc        = nack_fire && below_limit;
    assign push         = nack_fire && !below_limit;
    assign notice_ready = (state_q == ST_IDLE);
    assign notice_fire  = notice_valid && notice_ready;
    assign free         = notice_fire && slot_hit;
    assign pop          = (state_q == ST_IDLE) && (state_d == ST_SEND_DROPPED);

    rtrk_slot_table #(.SLOTS(FAULT_LIMIT), .VPN_W(VPN_W), .NUM_WARPS(NUM_WARPS)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc), .alloc_vpn(nack_vpn), .alloc_warp(nack_warp),
        .lookup_vpn(notice_vpn), .free_en(free),
        .hit(slot_hit), .hit_vpn(slot_vpn), .hit_warp(slot_warp),
        .any_free(slot_free), .warp_mask(slot_mask)
    );

    rtrk_drop_fifo #(.DEPTH(DROP_DEPTH), .VPN_W(VPN_W), .NUM_WARPS(NUM_WARPS)) u_drops (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_vpn(nack_vpn), .push_warp(nack_warp),
        .pop(pop), .head_vpn(q_vpn), .head_warp(q_warp),
        .empty(q_empty), .full(q_full), .warp_mask(q_mask)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (free)
                    state_d = ST_SEND_SERVICED;
                else if (!notice_valid && !q_empty && below_limit)
                    state_d = ST_SEND_DROPPED;
            end
            ST_SEND_SERVICED, ST_SEND_DROPPED: begin
                if (reissue_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            out_vpn_q  <= '0;
            out_warp_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(free);
            if (free) begin
                out_vpn_q  <= slot_vpn;
                out_warp_q <= slot_warp;
            end else if (pop) begin
                out_vpn_q  <= q_vpn;
                out_warp_q <= q_warp;
            end
        end
    end

    always_comb begin
        held_mask = '0;
        if (state_q != ST_IDLE) held_mask[out_warp_q] = 1'b1;
    end

    assign reissue_valid = (state_q != ST_IDLE);
    assign reissue_vpn   = out_vpn_q;
    assign reissue_warp  = out_warp_q;
    assign stall_mask    = slot_mask | q_mask | held_mask;

    // R3: the pending count never exceeds the limit
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FAULT_LIMIT));
    // R2: slot storage agrees with the count
    assert_count_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
        below_limit |-> slot_free);
    // R6: an empty count stays empty without a new serviced acknowledgement
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !alloc) |=> cnt_q == '0);
    // R9: a presented request holds until taken
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reissue_valid && !reissue_ready) |=> reissue_valid && $stable(reissue_vpn) && $stable(reissue_warp));
    // R7: an accepted acknowledgement stalls its warp
    assert_stall_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nack_fire |=> stall_mask[$past(nack_warp)]);
    // R5: a dropped request is popped only below the limit
    assert_drop_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_DROPPED && $past(state_q) == ST_IDLE) |-> $past(below_limit));
endmodule

// File: tb/replay_tracker_tb.sv
module replay_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nack_valid = 1'b0, notice_valid = 1'b0, reissue_ready = 1'b1;
    logic [19:0] nack_vpn = '0, notice_vpn = '0;
    logic [2:0]  nack_warp = '0;
    logic        nack_ready, notice_ready, reissue_valid;
    logic [19:0] reissue_vpn;
    logic [2:0]  reissue_warp;
    logic [7:0]  stall_mask;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    replay_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .nack_valid(nack_valid), .nack_ready(nack_ready), .nack_vpn(nack_vpn), .nack_warp(nack_warp),
        .notice_valid(notice_valid), .notice_ready(notice_ready), .notice_vpn(notice_vpn),
        .reissue_valid(reissue_valid), .reissue_ready(reissue_ready),
        .reissue_vpn(reissue_vpn), .reissue_warp(reissue_warp), .stall_mask(stall_mask)
    );

    typedef struct packed {
        logic       nv;
        logic [7:0] nvpn;
        logic [2:0] nw;
        logic       tv;
        logic [7:0] tvpn;
        logic       erv;
        logic [7:0] evpn;
        logic [7:0] emask;
    } vec_t;

    // limit 2: two slots, then the queue; notices release, idle cycles drain the queue
    localparam vec_t VEC [15] = '{
        '{1'b1, 8'h11, 3'd1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h02},
        '{1'b1, 8'h22, 3'd2, 1'b0, 8'h00, 1'b0, 8'h00, 8'h06},
        '{1'b1, 8'h33, 3'd3, 1'b0, 8'h00, 1'b0, 8'h00, 8'h0E},
        '{1'b1, 8'h44, 3'd4, 1'b0, 8'h00, 1'b0, 8'h00, 8'h1E},
        '{1'b0, 8'h00, 3'd0, 1'b1, 8'h22, 1'b1, 8'h22, 8'h1E},
        '{1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h1A},
        '{1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 8'h33, 8'h1A},
        '{1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h12},
        '{1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 8'h44, 8'h12},
        '{1'b1, 8'h33, 3'd3, 1'b0, 8'h00, 1'b0, 8'h00, 8'h0A},
        '{1'b0, 8'h00, 3'd0, 1'b1, 8'h99, 1'b0, 8'h00, 8'h0A},
        '{1'b0, 8'h00, 3'd0, 1'b1, 8'h11, 1'b1, 8'h11, 8'h0A},
        '{1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h08},
        '{1'b0, 8'h00, 3'd0, 1'b1, 8'h33, 1'b1, 8'h33, 8'h08},
        '{1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic nv, input logic [7:0] nvpn, input logic [2:0] nw,
                         input logic tv, input logic [7:0] tvpn);
        nack_valid = nv; nack_vpn = {12'h0, nvpn}; nack_warp = nw;
        notice_valid = tv; notice_vpn = {12'h0, tvpn};
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        chk("R1 reissue_valid", 32'(reissue_valid), 0);
        chk("R1 stall_mask", 32'(stall_mask), 0);
        rst_n = 1'b1;
        tick;
        chk("R1 nack_ready", 32'(nack_ready), 1);
        chk("R1 notice_ready", 32'(notice_ready), 1);

        // table walk: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < 15; i++) begin
            drive(VEC[i].nv, VEC[i].nvpn, VEC[i].nw, VEC[i].tv, VEC[i].tvpn);
            tick;
            chk($sformatf("R4/R5 step %0d reissue_valid", i), 32'(reissue_valid), 32'(VEC[i].erv));
            if (VEC[i].erv)
                chk($sformatf("R5/R10 step %0d reissue_vpn", i), reissue_vpn, {24'h0, VEC[i].evpn});
            chk($sformatf("R7 step %0d stall_mask", i), 32'(stall_mask), 32'(VEC[i].emask));
            chk($sformatf("R8 step %0d nack_ready", i), 32'(nack_ready), 1);
        end
        drive(0, 0, 0, 0, 0);

        // fill two slots and four queue entries
        for (int k = 0; k < 6; k++) begin
            drive(1, 8'h50 + 8'(k), 3'(k), 0, 0);
            tick;
        end
        drive(0, 0, 0, 0, 0);
        chk("R8 nack_ready low when full", 32'(nack_ready), 0);
        drive(1, 8'h77, 3'd7, 0, 0);
        tick;
        drive(0, 0, 0, 0, 0);
        chk("R8 ignored nack leaves mask", 32'(stall_mask), 32'h3F);

        reissue_ready = 1'b0;
        drive(0, 0, 0, 1, 8'h50);
        tick;
        drive(0, 0, 0, 0, 0);
        chk("R4 notice releases page", reissue_vpn, 32'h50);
        chk("R4 warp of released page", 32'(reissue_warp), 0);
        tick; tick;
        chk("R9 held valid", 32'(reissue_valid), 1);
        chk("R9 held page", reissue_vpn, 32'h50);
        chk("R9 notice_ready low", 32'(notice_ready), 0);
        chk("R8 ready after slot frees", 32'(nack_ready), 1);
        reissue_ready = 1'b1;
        tick;
        chk("R4 back to idle", 32'(reissue_valid), 0);
        tick;
        chk("R5 oldest dropped first valid", 32'(reissue_valid), 1);
        chk("R5 oldest dropped first page", reissue_vpn, 32'h52);
        chk("R5 oldest dropped warp", 32'(reissue_warp), 2);
        tick; tick;
        chk("R5 second dropped page", reissue_vpn, 32'h53);
        tick; tick;
        chk("R5 third dropped page", reissue_vpn, 32'h54);
        tick; tick;
        chk("R5 fourth dropped page", reissue_vpn, 32'h55);
        tick;
        chk("R7 only serviced warp left", 32'(stall_mask), 32'h02);

        drive(0, 0, 0, 1, 8'h51);
        tick;
        chk("R4 last slot released", reissue_vpn, 32'h51);
        drive(0, 0, 0, 0, 0);
        tick;
        chk("R7 mask empty", 32'(stall_mask), 0);
        drive(0, 0, 0, 1, 8'h51);
        tick;
        chk("R6 stale notice no reissue", 32'(reissue_valid), 0);
        tick;
        chk("R6 repeated stale notice no reissue", 32'(reissue_valid), 0);
        drive(1, 8'h60, 3'd0, 0, 0); tick;
        drive(1, 8'h61, 3'd1, 0, 0); tick;
        drive(1, 8'h62, 3'd2, 0, 0); tick;
        drive(0, 0, 0, 1, 8'h62);
        tick;
        drive(0, 0, 0, 0, 0);
        chk("R3 dropped page not matched by notice", 32'(reissue_valid), 0);
        chk("R6 count intact after stale notices", 32'(stall_mask), 32'h07);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule